// File: doc/BRIEF.md
# Four-of-Thirty-Six Muon Candidate Sorter

This block picks the four best muon candidates out of the thirty-six that twelve track-building sector processors deliver on every bunch crossing. Each sector processor contributes three 18-bit candidate words. The ranking depends only on a 7-bit key in each word. The key is a 5-bit transverse-momentum field, which is the more significant part, followed by a 2-bit quality field. The remaining 11 bits are payload. They travel with the winner and are not used in the ranking.

Selection is done in two stages of all-pairs comparison. The inputs are split into two halves of eighteen. Each half is ranked at the same time by a comparison matrix of 153 comparators, and each half keeps its best four. A second matrix of 28 comparators then merges these eight survivors into the final four. Between stages, a survivor is carried only as its key and its 6-bit source index.

In the last stage each winner's source index pulls its payload out of the delayed input set. A per-rank programmable table, addressed by the winner's key, supplies the upper bits of the 22-bit output word. The tables are loaded and read back through a simple address/data port. A new set of candidates is accepted on every clock, and each set appears at the outputs a fixed number of cycles later.

Top module: `muon_sorter_top`

## Requirements
- R1: Candidate i (0 to 35) is `in_words[i*18 +: 18]`. Its key is bits [17:11]. Of the key, bits [17:13] are momentum and bits [12:11] are quality, so any momentum difference outweighs any quality difference. Bits [10:0] are payload.
- R2: The four candidates with the largest keys appear in descending key order as ranks 0 to 3. Rank r is carried on `out_words[r*22 +: 22]`, `out_src[r*6 +: 6]` and `out_present[r]`, and `out_src` gives the winner's index i.
- R3: When two candidates have equal keys, the one with the lower index i ranks higher. This also holds for two candidates taken from different halves.
- R4: A key of zero marks an empty candidate, and an empty candidate never ranks above a non-empty one. A rank with no non-empty candidate has `out_present` 0, `out_words` 0 and `out_src` 0. Present ranks are packed from rank 0 upward.
- R5: For a present rank r, the output word is the concatenation of table r's entry at the winner's key (bits [21:11]) and the winner's payload (bits [10:0]).
- R6: Suppose a set is driven with `in_valid` high before rising edge E. Its results and `out_valid` high appear right after edge E+3 and not before. Sets driven on consecutive cycles come out on consecutive cycles.
- R7: When `tbl_we` is high at a rising edge, `tbl_wdata` is written into table `tbl_sel` at entry `tbl_addr`.
- R8: After each rising edge, `tbl_rdata` holds the entry at (`tbl_sel`, `tbl_addr`) as it stood before any write at that same edge.
- R9: When a table write lands on the same edge that forms an output word using that entry, the output uses the old contents. Later sets use the new contents.
- R10: While `rst_n` is low at a rising edge, `out_valid`, `out_present`, `out_words`, `out_src` and `tbl_rdata` become zero.
- R11: All four winners may come from the same half, whether indices 0 to 17 or indices 18 to 35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Candidate set present this cycle |
| in_words | input | 648 | Thirty-six 18-bit candidate words |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table (rank) select |
| tbl_addr | input | 7 | Table entry address (key value) |
| tbl_wdata | input | 11 | Table write data |
| tbl_rdata | output | 11 | Registered table read data |
| out_valid | output | 1 | Output set valid |
| out_present | output | 4 | Per-rank non-empty flag |
| out_words | output | 88 | Four 22-bit formatted winners |
| out_src | output | 24 | Four 6-bit winner source indices |

## Verification
The risky overlap is between a table write and the output stage that reads the same table in that cycle. The bench sends a set and then schedules a write to the rank-0 entry at the winner's key so that it lands on exactly the edge that forms that set's output. It expects the old word at the outputs and the old value on the read-back port. It then resends the same set and expects the new word. Back-to-back sets are also checked: four consecutive sets must emerge on four consecutive cycles, each matched against its own expected ranking.

// File: rtl/muon_sort_pkg.sv
// Package: shared sizes and the candidate record passed between sort stages.
// Assumes 36 inputs split evenly into two ranking halves.
package muon_sort_pkg;
    parameter int N_SECTOR   = 12;
    parameter int PER_SECTOR = 3;
    parameter int N_CAND     = N_SECTOR * PER_SECTOR;
    parameter int WORD_W     = 18;
    parameter int PT_W       = 5;
    parameter int QUAL_W     = 2;
    parameter int KEY_W      = PT_W + QUAL_W;
    parameter int PAY_W      = WORD_W - KEY_W;
    parameter int SRC_W      = $clog2(N_CAND);
    parameter int N_BEST     = 4;
    parameter int N_GROUP    = 2;
    parameter int GROUP_SZ   = N_CAND / N_GROUP;
    parameter int MERGE_SZ   = N_GROUP * N_BEST;
    parameter int OUT_W      = 22;
    parameter int LUT_W      = OUT_W - PAY_W;
    parameter int RANK_W     = $clog2(N_BEST);
    parameter int LUT_DEPTH  = 2 ** KEY_W;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [SRC_W-1:0] src;
    } cand_t;
endpackage

// File: rtl/muon_rank_net.sv
// Module: all-pairs ranking network. Every pair of inputs is compared once
// (N*(N-1)/2 comparators). A candidate's place is the number of rivals that
// beat it, and the first K places are driven out. Purely combinational.
// Assumes source indices are unique, which makes the order total.
module muon_rank_net
    import muon_sort_pkg::*;
#(
    parameter int N = 18,
    parameter int K = 4
) (
    input  cand_t cand_i [N],
    output cand_t best_o [K]
);
    localparam int CNT_W = $clog2(N + 1);

    logic             win  [N][N];
    logic [CNT_W-1:0] lost [N];

    // One comparator per unordered pair; the mirror entry is its inverse.
    for (genvar gi = 0; gi < N; gi++) begin : g_row
        for (genvar gj = 0; gj < N; gj++) begin : g_col
            if (gi < gj) begin : g_cmp
                assign win[gi][gj] = (cand_i[gi].key > cand_i[gj].key) ||
                                     ((cand_i[gi].key == cand_i[gj].key) &&
                                      (cand_i[gi].src < cand_i[gj].src));
            end else if (gi > gj) begin : g_mir
                assign win[gi][gj] = !win[gj][gi];
            end else begin : g_diag
                assign win[gi][gj] = 1'b0;
            end
        end
    end

    // Count how many rivals beat each candidate.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            lost[i] = '0;
            for (int j = 0; j < N; j++) begin
                lost[i] = lost[i] + CNT_W'(win[j][i]);
            end
        end
    end

    // Route the candidate holding each of the first K places to its slot.
    always_comb begin
        for (int r = 0; r < K; r++) begin
            best_o[r] = '0;
            for (int i = 0; i < N; i++) begin
                if (lost[i] == CNT_W'(r)) begin
                    best_o[r] = best_o[r] | cand_i[i];
                end
            end
        end
    end
endmodule

// File: rtl/muon_out_fmt.sv
// Module: output formatter. It fetches each winner's payload by source index,
// looks up the upper word bits in a per-rank table addressed by key, and
// registers the result. It also holds the table write/read port.
// Assumes the tables are loaded before use; they are RAM and are not reset.
module muon_out_fmt
    import muon_sort_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_i,
    input  cand_t                     best_i [N_BEST],
    input  logic [PAY_W-1:0]          pay_i  [N_CAND],
    input  logic                      lut_we,
    input  logic [RANK_W-1:0]         lut_sel,
    input  logic [KEY_W-1:0]          lut_addr,
    input  logic [LUT_W-1:0]          lut_wdata,
    output logic [LUT_W-1:0]          lut_rdata,
    output logic                      valid_o,
    output logic [N_BEST-1:0]         present_o,
    output logic [N_BEST*OUT_W-1:0]   words_o,
    output logic [N_BEST*SRC_W-1:0]   src_o
);
    logic [LUT_W-1:0] lut [N_BEST][LUT_DEPTH];

    // Table write port.
    always_ff @(posedge clk) begin
        if (lut_we) begin
            lut[lut_sel][lut_addr] <= lut_wdata;
        end
    end

    // Registered read-back; it sees contents from before a same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n) lut_rdata <= '0;
        else        lut_rdata <= lut[lut_sel][lut_addr];
    end

    // Form and register the four output words, blanking empty ranks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            present_o <= '0;
            words_o   <= '0;
            src_o     <= '0;
        end else begin
            valid_o <= valid_i;
            for (int r = 0; r < N_BEST; r++) begin
                if (best_i[r].key != '0) begin
                    present_o[r]                <= 1'b1;
                    words_o[r*OUT_W +: OUT_W]   <= {lut[r][best_i[r].key],
                                                    pay_i[best_i[r].src]};
                    src_o[r*SRC_W +: SRC_W]     <= best_i[r].src;
                end else begin
                    present_o[r]                <= 1'b0;
                    words_o[r*OUT_W +: OUT_W]   <= '0;
                    src_o[r*SRC_W +: SRC_W]     <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/muon_sorter_top.sv
// Module: four-of-thirty-six sorter top. Its pipeline is: input capture, then
// two parallel 4-of-18 rankers, then a 4-of-8 merge, then the output
// formatter. The latency is four registers and a new set is taken every clock.
// Only the payload bits are delayed alongside the key/index records.
module muon_sorter_top
    import muon_sort_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_CAND*WORD_W-1:0]  in_words,
    input  logic                      tbl_we,
    input  logic [RANK_W-1:0]         tbl_sel,
    input  logic [KEY_W-1:0]          tbl_addr,
    input  logic [LUT_W-1:0]          tbl_wdata,
    output logic [LUT_W-1:0]          tbl_rdata,
    output logic                      out_valid,
    output logic [N_BEST-1:0]         out_present,
    output logic [N_BEST*OUT_W-1:0]   out_words,
    output logic [N_BEST*SRC_W-1:0]   out_src
);
    cand_t            st0_cand [N_CAND];
    logic [PAY_W-1:0] st0_pay  [N_CAND];
    logic             st0_v;

    cand_t            grp_best [MERGE_SZ];
    cand_t            st1_best [MERGE_SZ];
    logic [PAY_W-1:0] st1_pay  [N_CAND];
    logic             st1_v;

    cand_t            mrg_best [N_BEST];
    cand_t            st2_best [N_BEST];
    logic [PAY_W-1:0] st2_pay  [N_CAND];
    logic             st2_v;

    // Stage 0: split each input word into a key/index record and its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st0_v <= 1'b0;
            for (int i = 0; i < N_CAND; i++) begin
                st0_cand[i] <= '0;
                st0_pay[i]  <= '0;
            end
        end else begin
            st0_v <= in_valid;
            for (int i = 0; i < N_CAND; i++) begin
                st0_cand[i].key <= in_words[i*WORD_W + PAY_W +: KEY_W];
                st0_cand[i].src <= SRC_W'(i);
                st0_pay[i]      <= in_words[i*WORD_W +: PAY_W];
            end
        end
    end

    // Stage 1: one ranking network per half, running side by side.
    for (genvar g = 0; g < N_GROUP; g++) begin : g_half
        cand_t sub_in  [GROUP_SZ];
        cand_t sub_out [N_BEST];
        for (genvar k = 0; k < GROUP_SZ; k++) begin : g_in
            assign sub_in[k] = st0_cand[g*GROUP_SZ + k];
        end
        muon_rank_net #(.N(GROUP_SZ), .K(N_BEST)) u_rank (
            .cand_i (sub_in),
            .best_o (sub_out)
        );
        for (genvar k = 0; k < N_BEST; k++) begin : g_out
            assign grp_best[g*N_BEST + k] = sub_out[k];
        end
    end

    // Stage 1 register: the eight survivors plus the delayed payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1_v <= 1'b0;
            for (int k = 0; k < MERGE_SZ; k++) st1_best[k] <= '0;
            for (int i = 0; i < N_CAND; i++)   st1_pay[i]  <= '0;
        end else begin
            st1_v <= st0_v;
            for (int k = 0; k < MERGE_SZ; k++) st1_best[k] <= grp_best[k];
            for (int i = 0; i < N_CAND; i++)   st1_pay[i]  <= st0_pay[i];
        end
    end

    // Stage 2: the merge network picks the final four out of eight.
    muon_rank_net #(.N(MERGE_SZ), .K(N_BEST)) u_merge (
        .cand_i (st1_best),
        .best_o (mrg_best)
    );

    // Stage 2 register: the final ranking plus the delayed payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st2_v <= 1'b0;
            for (int k = 0; k < N_BEST; k++) st2_best[k] <= '0;
            for (int i = 0; i < N_CAND; i++) st2_pay[i]  <= '0;
        end else begin
            st2_v <= st1_v;
            for (int k = 0; k < N_BEST; k++) st2_best[k] <= mrg_best[k];
            for (int i = 0; i < N_CAND; i++) st2_pay[i]  <= st1_pay[i];
        end
    end

    // Stage 3: table lookup and the output register.
    muon_out_fmt u_fmt (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_i   (st2_v),
        .best_i    (st2_best),
        .pay_i     (st2_pay),
        .lut_we    (tbl_we),
        .lut_sel   (tbl_sel),
        .lut_addr  (tbl_addr),
        .lut_wdata (tbl_wdata),
        .lut_rdata (tbl_rdata),
        .valid_o   (out_valid),
        .present_o (out_present),
        .words_o   (out_words),
        .src_o     (out_src)
    );
endmodule

// File: rtl/muon_sort_chk.sv
// Module: property checker bound to the sorter top. It watches the output
// ports and the registered final ranking, and uses a counter of edges since
// reset so that no property looks back past the reset.
module muon_sort_chk
    import muon_sort_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic [N_BEST-1:0]        out_present,
    input logic [N_BEST*OUT_W-1:0]  out_words,
    input logic [N_BEST*SRC_W-1:0]  out_src,
    input logic                     st2_v,
    input cand_t                    st2_best [N_BEST]
);
    logic [2:0] since_rst;

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end

    AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R6

    for (genvar r = 0; r < N_BEST; r++) begin : g_rank
        AST_EMPTY_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
            !out_present[r] |-> (out_words[r*OUT_W +: OUT_W] == '0 &&
                                 out_src[r*SRC_W +: SRC_W] == '0)); // R4
        if (r < N_BEST - 1) begin : g_pair
            AST_PRESENT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
                out_present[r+1] |-> out_present[r]); // R4
            AST_RANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
                st2_v |-> ((st2_best[r].key > st2_best[r+1].key) ||
                           ((st2_best[r].key == st2_best[r+1].key) &&
                            (st2_best[r].src < st2_best[r+1].src)))); // R3
        end
        for (genvar s = r + 1; s < N_BEST; s++) begin : g_other
            AST_SRC_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
                (out_valid && out_present[r] && out_present[s]) |->
                (out_src[r*SRC_W +: SRC_W] != out_src[s*SRC_W +: SRC_W])); // R2
        end
    end
endmodule

bind muon_sorter_top muon_sort_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_present (out_present),
    .out_words   (out_words),
    .out_src     (out_src),
    .st2_v       (st2_v),
    .st2_best    (st2_best)
);

// File: tb/sim_muon_sorter_top.sv
`timescale 1ns/1ps
// Directed bench for the sorter: one task per scenario, each checking itself.
module sim_muon_sorter_top;
    localparam int NC = 36;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [647:0]  in_words = '0;
    logic          tbl_we = 1'b0;
    logic [1:0]    tbl_sel = '0;
    logic [6:0]    tbl_addr = '0;
    logic [10:0]   tbl_wdata = '0;
    logic [10:0]   tbl_rdata;
    logic          out_valid;
    logic [3:0]    out_present;
    logic [87:0]   out_words;
    logic [23:0]   out_src;

    int checks = 0;
    int fails  = 0;

    logic [10:0] shadow [4][128];
    logic [17:0] cv [NC];
    logic [17:0] seqs [4][NC];
    logic [5:0]  e_src  [4];
    logic        e_pres [4];
    logic [21:0] e_word [4];

    always #10 clk = ~clk;

    muon_sorter_top u0 (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_words (in_words),
        .tbl_we (tbl_we), .tbl_sel (tbl_sel), .tbl_addr (tbl_addr),
        .tbl_wdata (tbl_wdata), .tbl_rdata (tbl_rdata), .out_valid (out_valid),
        .out_present (out_present), .out_words (out_words), .out_src (out_src)
    );

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [10:0] lutv(input int r, input int k);
        return 11'((r * 97 + k * 29 + 3) ^ (k << 4));
    endfunction

    function automatic logic [17:0] mk(input int pt, input int q, input int pay);
        return {5'(pt), 2'(q), 11'(pay)};
    endfunction

    task automatic drive(input logic [17:0] c [NC]);
        for (int i = 0; i < NC; i++) in_words[i*18 +: 18] = c[i];
    endtask

    // Reference ranking: strictly larger key wins, the earlier index wins ties.
    task automatic model(input logic [17:0] c [NC]);
        logic used [NC];
        for (int i = 0; i < NC; i++) used[i] = 1'b0;
        for (int r = 0; r < 4; r++) begin
            int best = -1;
            for (int i = 0; i < NC; i++)
                if (!used[i] && (best < 0 || c[i][17:11] > c[best][17:11])) best = i;
            used[best] = 1'b1;
            if (c[best][17:11] == 7'd0) begin
                e_pres[r] = 1'b0; e_src[r] = '0; e_word[r] = '0;
            end else begin
                e_pres[r] = 1'b1; e_src[r] = 6'(best);
                e_word[r] = {shadow[r][c[best][17:11]], c[best][10:0]};
            end
        end
    endtask

    task automatic compare(input string req);
        chk({req, " valid"}, 64'(out_valid), 64'd1);
        for (int r = 0; r < 4; r++) begin
            chk({req, " present"}, 64'(out_present[r]), 64'(e_pres[r]));
            chk({req, " src"},     64'(out_src[r*6 +: 6]), 64'(e_src[r]));
            chk({req, " word"},    64'(out_words[r*22 +: 22]), 64'(e_word[r]));
        end
    endtask

    // One set through the pipe: valid must be low after E+2 and high after E+3.
    task automatic run_set(input string req);
        @(negedge clk); drive(cv); in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk); in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); chk({req, " R6 early"}, 64'(out_valid), 64'd0);
        @(posedge clk);
        @(negedge clk); model(cv); compare(req);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R10 valid",   64'(out_valid), 64'd0);
        chk("R10 present", 64'(out_present), 64'd0);
        chk("R10 words",   64'(out_words), 64'd0);
        chk("R10 src",     64'(out_src), 64'd0);
        chk("R10 rdata",   64'(tbl_rdata), 64'd0);
    endtask

    task automatic t_load_tables();
        for (int r = 0; r < 4; r++)
            for (int k = 0; k < 128; k++) begin
                @(negedge clk);
                tbl_we = 1'b1; tbl_sel = 2'(r); tbl_addr = 7'(k); tbl_wdata = lutv(r, k);
                shadow[r][k] = lutv(r, k);
            end
        @(negedge clk); tbl_we = 1'b0;
        for (int n = 0; n < 6; n++) begin
            tbl_sel = 2'(n % 4); tbl_addr = 7'(n * 23 + 5);
            @(negedge clk);
            chk("R7 R8 readback", 64'(tbl_rdata), 64'(shadow[n % 4][n * 23 + 5]));
        end
    endtask

    task automatic t_distinct();
        for (int i = 0; i < NC; i++) cv[i] = mk((i * 11) % 31 + 1, i % 4, i * 7 + 1);
        run_set("R1 R2 R5 distinct");
    endtask

    task automatic t_momentum_first();
        for (int i = 0; i < NC; i++) cv[i] = mk(1, 0, i);
        cv[9]  = mk(2, 3, 11'h155);
        cv[27] = mk(3, 0, 11'h2aa);
        run_set("R1 momentum over quality");
        chk("R1 rank0 src", 64'(out_src[5:0]), 64'd27);
        chk("R1 rank1 src", 64'(out_src[11:6]), 64'd9);
    endtask

    task automatic t_upper_half();
        for (int i = 0; i < NC; i++) cv[i] = mk(2, 1, i);
        cv[30] = mk(20, 1, 30); cv[31] = mk(25, 2, 31);
        cv[32] = mk(18, 3, 32); cv[33] = mk(31, 0, 33);
        run_set("R11 upper half");
        chk("R11 rank3 src", 64'(out_src[23:18]), 64'd32);
        for (int i = 0; i < NC; i++) cv[i] = mk(i < 18 ? 30 - i : 1, 2, i);
        run_set("R11 lower half");
    endtask

    task automatic t_ties();
        for (int i = 0; i < NC; i++) cv[i] = mk(9, 2, 100 + i);
        run_set("R3 all equal");
        chk("R3 rank3 src", 64'(out_src[23:18]), 64'd3);
        for (int i = 0; i < NC; i++) cv[i] = mk(1, 1, i);
        cv[20] = mk(17, 1, 20); cv[5] = mk(17, 1, 5);
        run_set("R3 cross half tie");
        chk("R3 rank0 src", 64'(out_src[5:0]), 64'd5);
    endtask

    task automatic t_empty();
        for (int i = 0; i < NC; i++) cv[i] = '0;
        cv[7] = mk(0, 1, 7); cv[29] = mk(4, 0, 29);
        run_set("R4 two present");
        chk("R4 present mask", 64'(out_present), 64'h3);
        for (int i = 0; i < NC; i++) cv[i] = mk(0, 0, i + 1);
        run_set("R4 all empty");
        chk("R4 none present", 64'(out_present), 64'h0);
    endtask

    // Four sets on consecutive cycles; each must leave on its own cycle.
    task automatic t_back_to_back();
        for (int n = 0; n < 4; n++)
            for (int i = 0; i < NC; i++) seqs[n][i] = mk((i * (n + 3) + n) % 32, (i + n) % 4, i + 64 * n);
        for (int cyc = 0; cyc < 8; cyc++) begin
            @(negedge clk);
            if (cyc == 3) chk("R6 not yet", 64'(out_valid), 64'd0);
            if (cyc >= 4) begin
                for (int i = 0; i < NC; i++) cv[i] = seqs[cyc - 4][i];
                model(cv); compare("R6 back to back");
            end
            if (cyc < 4) begin
                for (int i = 0; i < NC; i++) cv[i] = seqs[cyc][i];
                drive(cv); in_valid = 1'b1;
            end else in_valid = 1'b0;
        end
        @(negedge clk); chk("R6 drained", 64'(out_valid), 64'd0);
    endtask

    // A table write lands on the very edge that forms the output using it.
    task automatic t_collision();
        logic [10:0] oldv, newv;
        for (int i = 0; i < NC; i++) cv[i] = mk(3, 1, i);
        cv[14] = mk(22, 2, 11'h3c3);
        oldv = shadow[0][{5'd22, 2'd2}];
        newv = ~oldv;
        tbl_sel = 2'd0; tbl_addr = {5'd22, 2'd2};
        @(negedge clk); drive(cv); in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); tbl_we = 1'b1; tbl_wdata = newv;
        @(negedge clk); tbl_we = 1'b0;
        model(cv); compare("R9 same-edge write");
        chk("R9 old word", 64'(out_words[21:11]), 64'(oldv));
        chk("R8 old rdata", 64'(tbl_rdata), 64'(oldv));
        @(negedge clk); chk("R7 new rdata", 64'(tbl_rdata), 64'(newv));
        shadow[0][{5'd22, 2'd2}] = newv;
        run_set("R9 later set");
        chk("R9 new word", 64'(out_words[21:11]), 64'(newv));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        t_load_tables();
        t_distinct();
        t_momentum_first();
        t_upper_half();
        t_ties();
        t_empty();
        t_back_to_back();
        t_collision();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule